// File: doc/BRIEF.md
# Gated Timer with Pulse Acquisition

A 16-bit up-counter for measuring time or counting events under the control of a gate. Each count step comes from one of four clock-source enables. The step rate can be divided by 1, 2, 4 or 8. A gate signal, taken from one of four sources, can qualify the counter. The gate is processed in stages, in this order:

1. An optional inversion.
2. An optional toggle stage. With the toggle stage on, the counter runs for one full period of the gate instead of one phase.
3. An optional one-shot stage. With the one-shot stage on, counting is limited to a single window armed by software.

When the processed gate falls, the block raises a sticky completion flag. In one-shot mode the same fall also drops the armed bit.

Software loads the count one byte at a time. It reads the count, the processed gate level and the armed bit directly. Both interrupt flags stay set until an explicit clear strobe. All sources are enables or levels in the single system clock domain.

Top module: `gated_timer`

## Requirements
- R1: After synchronous reset, the count is 0x0000 and `ovf_flag`, `gate_flag`, `gate_level` and `acq_busy` are all 0.
- R2: `clk_sel` picks the count source: 0 = `ins_tick` enable, 1 = every system clock, 2 = rising edge of `ext_clk`, 3 = `aux_tick` enable. With prescale 1 and the gate unused, each source event adds one to the count, taking effect at the clock edge where the event is present.
- R3: While `timer_on` is 0 the count does not change, except by a write.
- R4: `prescale` codes 0, 1, 2, 3 give one count per 1, 2, 4, 8 source events. The divider restarts from zero while `timer_on` is 0 and on any count write.
- R5: An increment from 0xFFFF wraps the count to 0x0000 and sets `ovf_flag`. The flag stays at 1 until `ovf_clr` is pulsed; a new overflow in the same cycle wins over the clear.
- R6: `wr_hi` loads `wdata` into count bits [15:8] and `wr_lo` loads it into bits [7:0]. A write in a cycle replaces that cycle's increment.
- R7: With `gate_en` at 0 the gate has no effect. With `gate_en` at 1 the counter advances only while `gate_level` is 1. `gate_sel` picks bit `gate_sel` of `gate_src`.
- R8: `gate_inv` = 1 inverts the selected gate source before the toggle and one-shot stages.
- R9: With `toggle_en` at 1, each rising edge of the polarity-corrected gate flips the effective gate. The counter then runs from one rising edge to the next. The toggle state is cleared while `toggle_en` is 0.
- R10: With `single_en` at 1, the effective gate is open only while `acq_busy` is 1. A `go_set` pulse sets `acq_busy`. `acq_busy` returns to 0 in the cycle the effective gate falls, so a single window is measured. `acq_busy` is held at 0 while `single_en` is 0.
- R11: While `gate_en` is 1, a fall of `gate_level` sets `gate_flag` in the same cycle. The flag stays at 1 until `gflag_clr` is pulsed.
- R12: `gate_level` is the gate after inversion, toggle and one-shot processing. It follows a change of the selected source with two cycles of latency.
- R13: With `ext_sync` at 0, an `ext_clk` rise advances the count at the second clock edge after the rise. With `ext_sync` at 1 it advances the count at the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Count source select |
| ins_tick | input | 1 | Internal rate enable (source 0) |
| aux_tick | input | 1 | Auxiliary oscillator enable (source 3) |
| ext_clk | input | 1 | External clock level (source 2) |
| ext_sync | input | 1 | Add a synchronizer stage on the external clock |
| prescale | input | 2 | Divider code: 1, 2, 4, 8 |
| timer_on | input | 1 | Counter run enable |
| gate_en | input | 1 | Gate qualification enable |
| gate_sel | input | 2 | Gate source select |
| gate_src | input | 4 | Candidate gate sources |
| gate_inv | input | 1 | Invert selected gate |
| toggle_en | input | 1 | Toggle (full period) gate mode |
| single_en | input | 1 | One-shot acquisition mode |
| go_set | input | 1 | Arm one acquisition |
| wr_hi | input | 1 | Write strobe for count high byte |
| wr_lo | input | 1 | Write strobe for count low byte |
| wdata | input | 8 | Byte write data |
| ovf_clr | input | 1 | Clear overflow flag |
| gflag_clr | input | 1 | Clear gate completion flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| gate_flag | output | 1 | Sticky gate completion flag |
| gate_level | output | 1 | Processed gate level |
| acq_busy | output | 1 | One-shot armed bit |

## Verification
The assertions take for granted that strobes (`go_set`, both clears and both writes) last one cycle, and that `ext_clk` and `gate_src` are plain levels from the system clock domain. They also take for granted that modes change only while the gate path is idle. The bench drives every input on the falling clock edge and pulses each strobe for exactly one cycle. It changes `clk_sel`, `ext_sync`, `toggle_en` and `single_en` only with the timer stopped, the gate sources low, and a quiet interval before the measurement starts. Under these conditions no spurious edge comes from the synchronizer or the toggle stage.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  typedef enum logic [1:0] {
    SRC_INS = 2'd0,
    SRC_SYS = 2'd1,
    SRC_EXT = 2'd2,
    SRC_AUX = 2'd3
  } clk_src_e;
  localparam int SRC_SEL_W = 2;
endpackage

// File: rtl/gtmr_tick_gen.sv
module gtmr_tick_gen
  import gtmr_pkg::*;
#(
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SRC_SEL_W-1:0] clk_sel,
  input  logic                 ins_tick,
  input  logic                 aux_tick,
  input  logic                 ext_clk,
  input  logic                 ext_sync,
  input  logic [PS_W-1:0]      prescale,
  input  logic                 timer_on,
  input  logic                 pre_clr,
  output logic                 inc_tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_sample;
  logic                   ext_prev;
  logic                   ext_rise;
  logic                   src_tick;
  logic                   run_tick;
  logic [PRE_W-1:0]       pre_cnt;
  logic [PRE_W-1:0]       pre_mask;

  // external clock capture chain
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      ext_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      ext_prev <= ext_sample;
    end
  end

  assign ext_sample = ext_sync ? sync_q[SYNC_STAGES-1] : sync_q[0];
  assign ext_rise   = ext_sample & ~ext_prev;

  always_comb begin
    unique case (clk_src_e'(clk_sel))
      SRC_INS: src_tick = ins_tick;
      SRC_SYS: src_tick = 1'b1;
      SRC_EXT: src_tick = ext_rise;
      SRC_AUX: src_tick = aux_tick;
      default: src_tick = 1'b0;
    endcase
  end

  assign run_tick = src_tick & timer_on;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      pre_mask[i] = (i < int'(prescale));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pre_clr || !timer_on) begin
      pre_cnt <= '0;
    end else if (run_tick) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign inc_tick = run_tick && ((pre_cnt & pre_mask) == pre_mask);
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate #(
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<SEL_W)-1:0] gate_src,
  input  logic [SEL_W-1:0]      gate_sel,
  input  logic                  gate_inv,
  input  logic                  toggle_en,
  input  logic                  single_en,
  input  logic                  go_set,
  input  logic                  gate_en,
  input  logic                  gflag_clr,
  output logic                  gate_level,
  output logic                  acq_busy,
  output logic                  gate_flag
);
  logic pol_q;
  logic pol_prev;
  logic tog_q;
  logic lvl;
  logic win;
  logic gate_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q    <= 1'b0;
      pol_prev <= 1'b0;
    end else begin
      pol_q    <= gate_src[gate_sel] ^ gate_inv;
      pol_prev <= pol_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !toggle_en) begin
      tog_q <= 1'b0;
    end else if (pol_q && !pol_prev) begin
      tog_q <= ~tog_q;
    end
  end

  assign lvl       = toggle_en ? tog_q : pol_q;
  assign win       = single_en ? (acq_busy & lvl) : lvl;
  assign gate_fall = gate_level & ~win;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_level <= 1'b0;
      acq_busy   <= 1'b0;
      gate_flag  <= 1'b0;
    end else begin
      gate_level <= win;
      if (!single_en) begin
        acq_busy <= 1'b0;
      end else if (go_set) begin
        acq_busy <= 1'b1;
      end else if (gate_fall) begin
        acq_busy <= 1'b0;
      end
      if (gate_en && gate_fall) begin
        gate_flag <= 1'b1;
      end else if (gflag_clr) begin
        gate_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   count,
  output logic               ovf_flag
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic any_wr;
  assign any_wr = wr_hi | wr_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (any_wr) begin
        if (wr_hi) count[CNT_W-1:HALF] <= wdata;
        if (wr_lo) count[HALF-1:0]     <= wdata;
      end else if (inc) begin
        count <= count + 1'b1;
      end
      if (inc && !any_wr && count == CNT_MAX) begin
        ovf_flag <= 1'b1;
      end else if (ovf_clr) begin
        ovf_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 2,
  parameter int GSEL_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SRC_SEL_W-1:0]   clk_sel,
  input  logic                   ins_tick,
  input  logic                   aux_tick,
  input  logic                   ext_clk,
  input  logic                   ext_sync,
  input  logic [PS_W-1:0]        prescale,
  input  logic                   timer_on,
  input  logic                   gate_en,
  input  logic [GSEL_W-1:0]      gate_sel,
  input  logic [(1<<GSEL_W)-1:0] gate_src,
  input  logic                   gate_inv,
  input  logic                   toggle_en,
  input  logic                   single_en,
  input  logic                   go_set,
  input  logic                   wr_hi,
  input  logic                   wr_lo,
  input  logic [CNT_W/2-1:0]     wdata,
  input  logic                   ovf_clr,
  input  logic                   gflag_clr,
  output logic [CNT_W-1:0]       count,
  output logic                   ovf_flag,
  output logic                   gate_flag,
  output logic                   gate_level,
  output logic                   acq_busy
);
  logic step_tick;
  logic cnt_inc;

  gtmr_tick_gen #(
    .PS_W       (PS_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .ins_tick(ins_tick),
    .aux_tick(aux_tick),
    .ext_clk (ext_clk),
    .ext_sync(ext_sync),
    .prescale(prescale),
    .timer_on(timer_on),
    .pre_clr (wr_hi | wr_lo),
    .inc_tick(step_tick)
  );

  gtmr_gate #(
    .SEL_W(GSEL_W)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_src  (gate_src),
    .gate_sel  (gate_sel),
    .gate_inv  (gate_inv),
    .toggle_en (toggle_en),
    .single_en (single_en),
    .go_set    (go_set),
    .gate_en   (gate_en),
    .gflag_clr (gflag_clr),
    .gate_level(gate_level),
    .acq_busy  (acq_busy),
    .gate_flag (gate_flag)
  );

  assign cnt_inc = step_tick & (~gate_en | gate_level);

  gtmr_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (cnt_inc),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wdata   (wdata),
    .ovf_clr (ovf_clr),
    .count   (count),
    .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               timer_on,
  input logic               gate_en,
  input logic               single_en,
  input logic               go_set,
  input logic               wr_hi,
  input logic               wr_lo,
  input logic [CNT_W/2-1:0] wdata,
  input logic               ovf_clr,
  input logic               gflag_clr,
  input logic [CNT_W-1:0]   count,
  input logic               ovf_flag,
  input logic               gate_flag,
  input logic               gate_level,
  input logic               acq_busy
);
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!timer_on && !wr_hi && !wr_lo) |=> $stable(count));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r6_lo_write: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (count[CNT_W/2-1:0] == $past(wdata)));

  a_r6_hi_write: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (count[CNT_W-1:CNT_W/2] == $past(wdata)));

  a_r7_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (gate_en && !gate_level && !wr_hi && !wr_lo) |=> $stable(count));

  a_r10_idle_off: assert property (@(posedge clk) disable iff (rst)
    !single_en |=> !acq_busy);

  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_level) && $past(single_en) && !$past(go_set)) |-> !acq_busy);

  a_r11_flag_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_level) && $past(gate_en)) |-> gate_flag);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (gate_flag && !gflag_clr) |=> gate_flag);
endmodule

bind gated_timer gtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .timer_on  (timer_on),
  .gate_en   (gate_en),
  .single_en (single_en),
  .go_set    (go_set),
  .wr_hi     (wr_hi),
  .wr_lo     (wr_lo),
  .wdata     (wdata),
  .ovf_clr   (ovf_clr),
  .gflag_clr (gflag_clr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .gate_flag (gate_flag),
  .gate_level(gate_level),
  .acq_busy  (acq_busy)
);

// File: tb/tb_gated_timer.sv
module tb_gated_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clk_sel = 2'd1;
  logic        ins_tick = 0, aux_tick = 0, ext_clk = 0, ext_sync = 0;
  logic [1:0]  prescale = 0;
  logic        timer_on = 0, gate_en = 0;
  logic [1:0]  gate_sel = 0;
  logic [3:0]  gate_src = 0;
  logic        gate_inv = 0, toggle_en = 0, single_en = 0, go_set = 0;
  logic        wr_hi = 0, wr_lo = 0;
  logic [7:0]  wdata = 0;
  logic        ovf_clr = 0, gflag_clr = 0;
  logic [15:0] count;
  logic        ovf_flag, gate_flag, gate_level, acq_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] snap;

  always #10 clk = ~clk;

  gated_timer dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ins_tick(ins_tick),
    .aux_tick(aux_tick), .ext_clk(ext_clk), .ext_sync(ext_sync),
    .prescale(prescale), .timer_on(timer_on), .gate_en(gate_en),
    .gate_sel(gate_sel), .gate_src(gate_src), .gate_inv(gate_inv),
    .toggle_en(toggle_en), .single_en(single_en), .go_set(go_set),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata), .ovf_clr(ovf_clr),
    .gflag_clr(gflag_clr), .count(count), .ovf_flag(ovf_flag),
    .gate_flag(gate_flag), .gate_level(gate_level), .acq_busy(acq_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop everything, zero the count, clear flags
  task automatic quiesce();
    timer_on = 0; gate_en = 0; toggle_en = 0; single_en = 0; gate_inv = 0;
    gate_src = 0; gate_sel = 0; prescale = 0; clk_sel = 2'd1; ext_clk = 0;
    ins_tick = 0; aux_tick = 0;
    wr_hi = 1; wr_lo = 1; wdata = 0; ovf_clr = 1; gflag_clr = 1;
    step(1);
    wr_hi = 0; wr_lo = 0; ovf_clr = 0; gflag_clr = 0;
    step(4);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 gate_flag", gate_flag, 0);
    chk("R1 gate_level", gate_level, 0);
    chk("R1 acq_busy", acq_busy, 0);
  endtask

  task automatic t_sources();
    quiesce();
    timer_on = 1; step(10);
    chk("R2 system source", count, 10);
    timer_on = 0; step(5);
    chk("R3 hold while off", count, 10);
    quiesce();
    clk_sel = 2'd0; timer_on = 1;
    for (int i = 0; i < 12; i++) begin
      ins_tick = (i % 3 == 0);
      step(1);
    end
    ins_tick = 0;
    chk("R2 ins_tick source", count, 4);
    quiesce();
    clk_sel = 2'd3; timer_on = 1;
    for (int i = 0; i < 10; i++) begin
      aux_tick = (i % 2 == 0);
      step(1);
    end
    aux_tick = 0;
    chk("R2 aux_tick source", count, 5);
  endtask

  task automatic t_prescale();
    for (int p = 1; p < 4; p++) begin
      quiesce();
      prescale = 2'(p); timer_on = 1;
      step(8 << p);
      chk("R4 prescale", count, 8);
    end
  endtask

  task automatic t_ext();
    quiesce();
    clk_sel = 2'd2; ext_sync = 0; step(3);
    timer_on = 1; ext_clk = 1; step(1);
    chk("R13 nosync edge1", count, 0);
    step(1);
    chk("R13 nosync edge2", count, 1);
    ext_clk = 0; step(4);
    ext_sync = 1; step(4);
    ext_clk = 1; step(2);
    chk("R13 sync edge2", count, 1);
    step(1);
    chk("R13 sync edge3", count, 2);
    ext_clk = 0; step(3);
    ext_sync = 0;
  endtask

  task automatic t_overflow();
    quiesce();
    wr_hi = 1; wdata = 8'hFF; step(1);
    wr_hi = 0; wr_lo = 1; wdata = 8'hFE; step(1);
    wr_lo = 0;
    chk("R6 byte load", count, 16'hFFFE);
    timer_on = 1; step(1);
    chk("R5 pre-wrap", {ovf_flag, count}, {1'b0, 16'hFFFF});
    step(1);
    chk("R5 wrap", {ovf_flag, count}, {1'b1, 16'h0000});
    timer_on = 0; step(3);
    chk("R5 sticky", ovf_flag, 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk("R5 cleared", ovf_flag, 0);
  endtask

  task automatic t_write_priority();
    quiesce();
    timer_on = 1; wr_lo = 1; wdata = 8'h55; step(1);
    wr_lo = 0;
    chk("R6 write wins", count, 16'h0055);
    step(1);
    chk("R6 resume", count, 16'h0056);
    wr_hi = 1; wdata = 8'hAB; step(1);
    wr_hi = 0;
    chk("R6 hi write", count, 16'hAB56);
  endtask

  task automatic t_gate_level();
    quiesce();
    gate_en = 1; timer_on = 1; step(10);
    chk("R7 gate closed", count, 0);
    gate_src[0] = 1; step(2);
    chk("R12 level latency", gate_level, 1);
    step(5);
    gate_src[0] = 0; step(5);
    chk("R7 level window", count, 7);
    chk("R11 flag set", gate_flag, 1);
    chk("R12 level low", gate_level, 0);
    step(2);
    chk("R11 flag sticky", gate_flag, 1);
    gflag_clr = 1; step(1); gflag_clr = 0;
    chk("R11 flag cleared", gate_flag, 0);
    quiesce();
    gate_en = 1; gate_sel = 2'd2; gate_src[0] = 1; timer_on = 1; step(6);
    chk("R7 unselected ignored", count, 0);
    gate_src[2] = 1; step(4);
    gate_src[2] = 0; step(4);
    chk("R7 selected source", count, 4);
    quiesce();
    timer_on = 1; gate_src = 0; step(6);
    chk("R7 gate disabled", count, 6);
  endtask

  task automatic t_invert();
    quiesce();
    gate_en = 1; gate_inv = 1; timer_on = 1; step(4);
    snap = count; step(6);
    chk("R8 inverted low counts", count - snap, 6);
    gate_src[0] = 1; step(3);
    snap = count; step(6);
    chk("R8 inverted high stops", count - snap, 0);
  endtask

  task automatic t_toggle();
    quiesce();
    toggle_en = 1; gate_en = 1; timer_on = 1; step(3);
    gate_src[0] = 1; step(3); gate_src[0] = 0; step(5);
    gate_src[0] = 1; step(3); gate_src[0] = 0; step(8);
    chk("R9 full period", count, 8);
    chk("R11 toggle flag", gate_flag, 1);
  endtask

  task automatic t_single();
    quiesce();
    single_en = 1; gate_en = 1; timer_on = 1; step(2);
    gate_src[0] = 1; step(4); gate_src[0] = 0; step(4);
    chk("R10 unarmed ignored", count, 0);
    go_set = 1; step(1); go_set = 0;
    chk("R10 armed", acq_busy, 1);
    step(2);
    gate_src[0] = 1; step(6); gate_src[0] = 0; step(5);
    chk("R10 one window", count, 6);
    chk("R10 auto done", acq_busy, 0);
    chk("R11 acquisition flag", gate_flag, 1);
    gate_src[0] = 1; step(6); gate_src[0] = 0; step(5);
    chk("R10 second pulse ignored", count, 6);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_sources();
    t_prescale();
    t_ext();
    t_overflow();
    t_write_priority();
    t_gate_level();
    t_invert();
    t_toggle();
    t_single();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule